// File: doc/BRIEF.md
# Precise Taint-Tracking Bitwise Logic Unit

This unit is a combinational bitwise logic stage in which every data bit has a companion taint bit. It applies AND, OR or NOT to N-bit operands, chosen by a 2-bit opcode. Next to the data result it drives a shadow taint result. That result marks which output bits a tainted input could influence. The unit is used as the tracked counterpart of a plain logic stage, so that security analysis can follow where untrusted data flows.

The taint result is exact, not conservative. An AND bit is tainted only when a tainted input can really change it, given the value of the other input. A 0 on an untainted AND input masks the taint of the other input, and a 1 on an untainted OR input does the same. A select input can replace operand B with a constant set by a parameter. A second parameter decides whether that constant counts as tainted. There are no registers, no clock and no reset. Outputs follow the inputs in the same cycle.

Top module: `taint_logic_unit`

## Requirements
- R1: With opcode 0 (AND), each data output bit equals A AND B for that bit.
- R2: With opcode 0 (AND), each taint output bit is (A & Bt) | (B & At) | (At & Bt) for that bit, where At and Bt are the operand taints.
- R3: With opcode 1 (OR), each data output bit is A | B, and each taint output bit is (~A & Bt) | (~B & At) | (At & Bt).
- R4: With opcode 2 (NOT), the data output is ~A and the taint output equals At. Operand B and its taint have no effect on either output.
- R5: With opcode 3 (pass), the data output equals A and the taint output equals At. Operand B and its taint have no effect.
- R6: While the constant select input is 1, operand B is replaced by the parameter constant, and the B input pins are ignored. The replacing taint is all ones when the constants-tainted parameter is 1 and all zeros when it is 0.
- R7: The opcode encoding is 0 = AND, 1 = OR, 2 = NOT, 3 = pass. Exactly one operation is selected for every opcode value.
- R8: For every operation, an output taint bit is 1 exactly when flipping some subset of the tainted input bits that feed it changes that output bit.
- R9: Outputs depend only on the present inputs. No clock or reset is needed, and both outputs are valid in the same cycle the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | Operand A data |
| opAT | input | WIDTH | Taint bits of operand A |
| opB | input | WIDTH | Operand B data |
| opBT | input | WIDTH | Taint bits of operand B |
| opCode | input | 2 | Operation select: 0 AND, 1 OR, 2 NOT, 3 pass |
| useConst | input | 1 | 1 replaces operand B with the parameter constant |
| resY | output | WIDTH | Data result |
| resYT | output | WIDTH | Taint result |

## Verification
Both results are combinational, so each is due in the same cycle its inputs change, with no register delay. The bench changes the inputs just after a falling clock edge and samples a quarter period later, long before the next rising edge. Each sample therefore sees the settled response to exactly one stimulus. Expected taint is found by brute force: every subset of tainted input bits is flipped, and the bench checks whether the output bit changes. This is independent of the closed-form equations the design uses.

// File: rtl/taint_logic_pkg.sv
package taint_logic_pkg;

  typedef enum logic [1:0] {
    OP_AND  = 2'd0,
    OP_OR   = 2'd1,
    OP_NOT  = 2'd2,
    OP_PASS = 2'd3
  } opSel_e;

  typedef struct packed {
    logic selAnd;
    logic selOr;
    logic selNot;
    logic selPass;
    logic takeConst;
  } ctrlStrobes_t;

endpackage

// File: rtl/taint_logic_ctrl.sv
module taint_logic_ctrl
  import taint_logic_pkg::*;
(
  input  logic [1:0]   opCode,
  input  logic         useConst,
  output ctrlStrobes_t strobes
);

  opSel_e opSel;

  always_comb begin
    opSel = opSel_e'(opCode);
    strobes = '0;
    strobes.takeConst = useConst;
    case (opSel)
      OP_AND:  strobes.selAnd  = 1'b1;
      OP_OR:   strobes.selOr   = 1'b1;
      OP_NOT:  strobes.selNot  = 1'b1;
      default: strobes.selPass = 1'b1;
    endcase
  end

  // exactly one operation strobe is active for each opcode (R7)
  always_comb begin
    p_onehot_sel_r7: assert ($countones({strobes.selAnd, strobes.selOr,
                                         strobes.selNot, strobes.selPass}) == 1)
      else $error("operation strobes not one-hot");
  end

endmodule

// File: rtl/taint_logic_datapath.sv
module taint_logic_datapath
  import taint_logic_pkg::*;
#(
  parameter int          WIDTH         = 8,
  parameter logic [WIDTH-1:0] CONST_VAL = '0,
  parameter bit          CONST_TAINTED = 1'b0
) (
  input  ctrlStrobes_t     strobes,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opAT,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] opBT,
  output logic [WIDTH-1:0] resY,
  output logic [WIDTH-1:0] resYT
);

  localparam logic [WIDTH-1:0] CONST_TAINT_WORD = {WIDTH{CONST_TAINTED}};

  logic [WIDTH-1:0] effB;
  logic [WIDTH-1:0] effBT;
  logic [WIDTH-1:0] andY;
  logic [WIDTH-1:0] andT;
  logic [WIDTH-1:0] orY;
  logic [WIDTH-1:0] orT;

  // operand B source: pins or parameter constant (R6)
  assign effB  = strobes.takeConst ? CONST_VAL        : opB;
  assign effBT = strobes.takeConst ? CONST_TAINT_WORD : opBT;

  // per-bit shadow logic (R1, R2, R3)
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign andY[i] = opA[i] & effB[i];
    assign andT[i] = (opA[i] & effBT[i]) | (effB[i] & opAT[i]) | (opAT[i] & effBT[i]);
    assign orY[i]  = opA[i] | effB[i];
    assign orT[i]  = (~opA[i] & effBT[i]) | (~effB[i] & opAT[i]) | (opAT[i] & effBT[i]);
  end

  // result select (R4, R5)
  always_comb begin
    resY  = opA;
    resYT = opAT;
    if (strobes.selAnd) begin
      resY  = andY;
      resYT = andT;
    end else if (strobes.selOr) begin
      resY  = orY;
      resYT = orT;
    end else if (strobes.selNot) begin
      resY  = ~opA;
      resYT = opAT;
    end
  end

  always_comb begin
    if (strobes.selNot) begin
      p_not_taint_r4: assert (resYT == opAT && resY == ~opA)
        else $error("NOT result or taint wrong");
    end
    if (strobes.selPass) begin
      p_pass_through_r5: assert (resYT == opAT && resY == opA)
        else $error("pass result or taint wrong");
    end
    if (strobes.selAnd) begin
      // a clean zero on A forces a clean zero out
      p_and_mask_r2: assert (((~opA & ~opAT) & (resY | resYT)) == '0)
        else $error("AND masking violated");
    end
    if (strobes.selOr) begin
      // a clean one on A forces a clean one out
      p_or_mask_r3: assert (((opA & ~opAT) & (~resY | resYT)) == '0)
        else $error("OR masking violated");
    end
    if (strobes.takeConst && !CONST_TAINTED && (strobes.selAnd || strobes.selOr)) begin
      p_const_clean_r6: assert ((resYT & ~opAT) == '0)
        else $error("clean constant produced taint");
    end
  end

endmodule

// File: rtl/taint_logic_unit.sv
module taint_logic_unit
  import taint_logic_pkg::*;
#(
  parameter int               WIDTH         = 8,
  parameter logic [WIDTH-1:0] CONST_VAL     = '0,
  parameter bit               CONST_TAINTED = 1'b0
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opAT,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] opBT,
  input  logic [1:0]       opCode,
  input  logic             useConst,
  output logic [WIDTH-1:0] resY,
  output logic [WIDTH-1:0] resYT
);

  ctrlStrobes_t strobes;

  taint_logic_ctrl ctrl_i (
    .opCode   (opCode),
    .useConst (useConst),
    .strobes  (strobes)
  );

  taint_logic_datapath #(
    .WIDTH         (WIDTH),
    .CONST_VAL     (CONST_VAL),
    .CONST_TAINTED (CONST_TAINTED)
  ) dp_i (
    .strobes (strobes),
    .opA     (opA),
    .opAT    (opAT),
    .opB     (opB),
    .opBT    (opBT),
    .resY    (resY),
    .resYT   (resYT)
  );

endmodule

// File: tb/taint_logic_unit_tb_top.sv
module taint_logic_unit_tb_top;

  localparam int W = 4;
  localparam logic [W-1:0] KVAL = 4'b1010;

  logic clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic [W-1:0] opA, opAT, opB, opBT;
  logic [1:0]   opCode;
  logic         useConst;
  logic [W-1:0] yClean, ytClean, yDirty, ytDirty;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  taint_logic_unit #(.WIDTH(W), .CONST_VAL(KVAL), .CONST_TAINTED(1'b0)) dut_i (
    .opA(opA), .opAT(opAT), .opB(opB), .opBT(opBT), .opCode(opCode),
    .useConst(useConst), .resY(yClean), .resYT(ytClean));

  taint_logic_unit #(.WIDTH(W), .CONST_VAL(KVAL), .CONST_TAINTED(1'b1)) dut_ct_i (
    .opA(opA), .opAT(opAT), .opB(opB), .opBT(opBT), .opCode(opCode),
    .useConst(useConst), .resY(yDirty), .resYT(ytDirty));

  function automatic logic gateFn(input logic [1:0] op, input logic a, input logic b);
    case (op)
      2'd0: return a & b;
      2'd1: return a | b;
      2'd2: return ~a;
      default: return a;
    endcase
  endfunction

  // brute-force precise taint: flip every subset of tainted inputs (R8)
  function automatic logic bitTaint(input logic [1:0] op, input logic a, input logic at,
                                    input logic b, input logic bt);
    logic base = gateFn(op, a, b);
    for (int m = 1; m < 4; m++) begin
      if ((m[0] && !at) || (m[1] && !bt)) continue;
      if (gateFn(op, a ^ m[0], b ^ m[1]) != base) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic checkOne(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%b expected=%b (op=%0d const=%0b A=%b At=%b B=%b Bt=%b)",
               req, got, exp, opCode, useConst, opA, opAT, opB, opBT);
    end
  endtask

  task automatic applyAndCheck(input logic [1:0] op, input logic uc,
                               input logic [W-1:0] a, input logic [W-1:0] at,
                               input logic [W-1:0] b, input logic [W-1:0] bt);
    logic [W-1:0] expY, expTc, expTd;
    string rq;
    @(negedge clk);
    opCode = op; useConst = uc; opA = a; opAT = at; opB = b; opBT = bt;
    for (int i = 0; i < W; i++) begin
      logic bb = uc ? KVAL[i] : b[i];
      expY[i]  = gateFn(op, a[i], bb);
      expTc[i] = bitTaint(op, a[i], at[i], bb, uc ? 1'b0 : bt[i]);
      expTd[i] = bitTaint(op, a[i], at[i], bb, uc ? 1'b1 : bt[i]);
    end
    #5; // combinational: due in the same cycle (R9)
    case (op)
      2'd0: rq = uc ? "R1/R6" : "R1";
      2'd1: rq = uc ? "R3/R6" : "R3";
      2'd2: rq = "R4";
      default: rq = "R5";
    endcase
    checkOne({rq, " data R7"}, yClean, expY);
    checkOne({rq, " taint R8 R2"}, ytClean, expTc);
    checkOne({rq, " data tainted-const R6"}, yDirty, expY);
    checkOne({rq, " taint tainted-const R6"}, ytDirty, expTd);
  endtask

  initial begin : watchdog
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    bad++;
    total++;
    $display("FAIL watchdog: cycles=%0d expected<20000", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    opA = '0; opAT = '0; opB = '0; opBT = '0; opCode = 2'd0; useConst = 1'b0;
    #5;
    // quiescent state with all-zero inputs (R9)
    checkOne("R9 idle data", yClean, 4'b0000);
    checkOne("R9 idle taint", ytClean, 4'b0000);

    // masking corners for R2 and R3
    applyAndCheck(2'd0, 1'b0, 4'b0000, 4'b0000, 4'b1111, 4'b1111); // clean 0 masks B taint
    applyAndCheck(2'd1, 1'b0, 4'b1111, 4'b0000, 4'b0000, 4'b1111); // clean 1 masks B taint
    // R4/R5: B pins differ, outputs must not change
    applyAndCheck(2'd2, 1'b0, 4'b0110, 4'b0011, 4'b0000, 4'b0000);
    applyAndCheck(2'd2, 1'b0, 4'b0110, 4'b0011, 4'b1111, 4'b1111);
    applyAndCheck(2'd3, 1'b0, 4'b1001, 4'b0101, 4'b1111, 4'b1111);
    // R6: B pins ignored under the constant
    applyAndCheck(2'd0, 1'b1, 4'b1111, 4'b0000, 4'b0101, 4'b1111);

    // near-exhaustive sweep: each bit gets one of 16 (a,at,b,bt) combos
    for (int c = 0; c < 16; c++) begin
      for (int s = 0; s < 4; s++) begin
        logic [W-1:0] a, at, b, bt;
        for (int i = 0; i < W; i++) begin
          int code = (c + i * (3 * s + 1)) % 16;
          a[i] = code[0]; at[i] = code[1]; b[i] = code[2]; bt[i] = code[3];
        end
        for (int op = 0; op < 4; op++) begin
          for (int uc = 0; uc < 2; uc++) begin
            applyAndCheck(op[1:0], uc[0], a, at, b, bt);
          end
        end
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule